// File: doc/BRIEF.md
# Fixed Off-Time Chopper Controller

This block is the digital control for one H-bridge winding regulated by fixed off-time PWM current chopping. A direction bit picks which diagonal pair of switches conducts. A 2-bit level code picks the trip threshold. The code is passed straight to an external reference DAC. A synchronized comparator input reports when the winding current has reached that threshold. The block drives four gate enables, a high and a low switch on each of the two legs, A and B.

Every PWM cycle works the same way. An on-time drives a high side on one leg and a low side on the other. For a short window after the switches change, the comparator is ignored. Once the comparator trips, a one-shot off-time follows, and during it the current recirculates through both low sides. A dead time, with every switch off, separates any change that could let the two switches of one leg conduct together.

A sleep input, a fault input and the zero-current code each force all gates off at once. Each time the drive resumes, it first waits the dead time.

Top module: `chopper_ctrl`

## Requirements
- R1: While `rst_n` is low, all four gate enables are 0.
- R2: Enabling the drive (all of: `sleep_n`=1, `fault`=0, `level`!=2'b11) holds the gates off for the cycle of the change plus DEAD_CYC cycles. The on-time follows with `dir`=0 driving `hi_a`+`lo_b` and `dir`=1 driving `hi_b`+`lo_a`.
- R3: During the first BLANK_CYC cycles of an on-time, `trip` has no effect, and the on-time diagonal stays on.
- R4: After blanking, a high `trip` ends the on-time at the next clock edge. The high side turns off, the low side of the diagonal stays on, and a high side is only ever on during an on-time.
- R5: The off-time lasts OFF_CYC = clock kHz × 30 / 1000 cycles, or × 8.1 / 1000 when the short setting is chosen. Then all gates are off for DEAD_CYC cycles, and the same diagonal starts a new on-time.
- R6: During the off-time, the low side of the leg whose high side just opened turns on from DEAD_CYC cycles into the off-time until its end.
- R7: `ref_sel` always equals `level` (00 = 100 %, 01 = 67 %, 10 = 33 %). Code 2'b11 forces all gates off in the same cycle.
- R8: `fault`=1 forces all gates off in the same cycle, including straight after reset. When it clears, the start-up rule of R2 applies.
- R9: `sleep_n`=0 forces all gates off in the same cycle. When it returns to 1, the start-up rule of R2 applies.
- R10: A change of `dir` during an on-time or an off-time turns all gates off from the next cycle for DEAD_CYC cycles. The on-time then starts on the new diagonal.
- R11: The high and low gate of one leg are never on together, and neither gate of a leg turns on in the cycle right after its partner was on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dir | input | 1 | Direction: selects the conducting diagonal |
| level | input | 2 | Current level code; 2'b11 means zero current |
| trip | input | 1 | Synchronized current comparator output |
| sleep_n | input | 1 | Sleep request, active low |
| fault | input | 1 | Over-temperature or undervoltage indication |
| hi_a | output | 1 | High-side gate enable, leg A |
| lo_a | output | 1 | Low-side gate enable, leg A |
| hi_b | output | 1 | High-side gate enable, leg B |
| lo_b | output | 1 | Low-side gate enable, leg B |
| ref_sel | output | 2 | Reference scale select for the external DAC |

## Verification
A corrupted phase counter shows up on the gate pins as an on-time, off-time or dead time of the wrong length. The error is visible at the first phase boundary, within at most OFF_CYC cycles. A wrong latched direction drives the wrong diagonal at the very next on-time entry. A bad leg request drives both switches of one leg in the same cycle, which is a shoot-through. Checks are made on every cycle at the gate pins against a timeline derived from the requirements. A faulty blanking counter shows as an on-time that ends during the masked window, or as a trip that goes unanswered once the window has passed.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DEAD = 2'd1,
    ST_ON   = 2'd2,
    ST_OFF  = 2'd3
  } chop_state_e;

  localparam logic [1:0] LVL_ZERO = 2'b11;

  // true when the level code asks for a non-zero current
  function automatic logic level_drives(input logic [1:0] lvl);
    return lvl != LVL_ZERO;
  endfunction

  // one-shot length in clock cycles: 30 us or 8.1 us at clk_khz
  function automatic int unsigned off_cycles(input int unsigned clk_khz,
                                             input bit short_sel);
    longint unsigned ns;
    ns = short_sel ? 64'd8100 : 64'd30000;
    return int'((longint'(clk_khz) * ns) / 64'd1000000);
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/chop_timer.sv
module chop_timer #(
  parameter int unsigned W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         zero
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/chop_seq.sv
module chop_seq
  import chop_pkg::*;
#(
  parameter int unsigned OFF_CYC   = 1500,
  parameter int unsigned BLANK_CYC = 50,
  parameter int unsigned DEAD_CYC  = 25,
  parameter int unsigned W         = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         dir,
  input  logic         trip,
  input  logic [W-1:0] cnt,
  input  logic         zero,
  output logic         load,
  output logic [W-1:0] load_val,
  output chop_state_e  state,
  output logic         cur_dir,
  output logic         blank_active,
  output logic         trip_taken,
  output logic         rect_on
);

  localparam logic [W-1:0] DEAD_LOAD  = W'(DEAD_CYC - 1);
  localparam logic [W-1:0] BLANK_LOAD = W'(BLANK_CYC);
  localparam logic [W-1:0] OFF_LOAD   = W'(OFF_CYC - 1);
  localparam logic [W-1:0] RECT_MARK  = W'(OFF_CYC - 1 - DEAD_CYC);

  chop_state_e nxt;
  logic        dir_flip;
  logic        latch_dir;

  assign blank_active = (state == ST_ON) && !zero;
  assign rect_on      = (state == ST_OFF) && (cnt <= RECT_MARK);
  assign dir_flip     = ((state == ST_ON) || (state == ST_OFF)) && (dir != cur_dir);

  always_comb begin
    nxt        = state;
    load       = 1'b0;
    load_val   = '0;
    trip_taken = 1'b0;
    latch_dir  = 1'b0;
    if (!run) begin
      nxt = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          nxt      = ST_DEAD;
          load     = 1'b1;
          load_val = DEAD_LOAD;
        end
        ST_DEAD: begin
          if (zero) begin
            nxt       = ST_ON;
            load      = 1'b1;
            load_val  = BLANK_LOAD;
            latch_dir = 1'b1;
          end
        end
        ST_ON: begin
          if (dir_flip) begin
            nxt      = ST_DEAD;
            load     = 1'b1;
            load_val = DEAD_LOAD;
          end else if (trip && zero) begin
            trip_taken = 1'b1;
            nxt        = ST_OFF;
            load       = 1'b1;
            load_val   = OFF_LOAD;
          end
        end
        ST_OFF: begin
          if (dir_flip || zero) begin
            nxt      = ST_DEAD;
            load     = 1'b1;
            load_val = DEAD_LOAD;
          end
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cur_dir <= 1'b0;
    end else begin
      state <= nxt;
      if (latch_dir) cur_dir <= dir;
    end
  end

endmodule

// File: rtl/chop_leg.sv
module chop_leg (
  input  logic en,
  input  logic hi_req,
  input  logic lo_req,
  output logic hi,
  output logic lo,
  output logic clash
);

  // last-line interlock: conflicting requests open both switches
  assign clash = hi_req && lo_req;
  assign hi    = en && hi_req && !lo_req;
  assign lo    = en && lo_req && !hi_req;

endmodule

// File: rtl/chopper_ctrl.sv
module chopper_ctrl
  import chop_pkg::*;
#(
  parameter int unsigned CLK_KHZ   = 50000,
  parameter bit          SHORT_OFF = 1'b0,
  parameter int unsigned BLANK_CYC = 50,
  parameter int unsigned DEAD_CYC  = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dir,
  input  logic [1:0] level,
  input  logic       trip,
  input  logic       sleep_n,
  input  logic       fault,
  output logic       hi_a,
  output logic       lo_a,
  output logic       hi_b,
  output logic       lo_b,
  output logic [1:0] ref_sel
);

  localparam int unsigned OFF_CYC = off_cycles(CLK_KHZ, SHORT_OFF);
  localparam int unsigned CNT_W   = $clog2(max3(OFF_CYC, BLANK_CYC, DEAD_CYC) + 1);
  localparam int unsigned NLEG    = 2;

  logic             run;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cnt;
  logic             zero;
  chop_state_e      state;
  logic             cur_dir;
  logic             blank_active;
  logic             trip_taken;
  logic             rect_on;
  logic             st_on;
  logic             st_off;
  logic [NLEG-1:0]  hi_req;
  logic [NLEG-1:0]  lo_req;
  logic [NLEG-1:0]  gate_hi;
  logic [NLEG-1:0]  gate_lo;
  logic [NLEG-1:0]  leg_clash;

  assign run     = sleep_n && !fault && level_drives(level);
  assign ref_sel = level;
  assign st_on   = (state == ST_ON);
  assign st_off  = (state == ST_OFF);

  chop_timer #(.W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .cnt      (cnt),
    .zero     (zero)
  );

  chop_seq #(
    .OFF_CYC   (OFF_CYC),
    .BLANK_CYC (BLANK_CYC),
    .DEAD_CYC  (DEAD_CYC),
    .W         (CNT_W)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .run          (run),
    .dir          (dir),
    .trip         (trip),
    .cnt          (cnt),
    .zero         (zero),
    .load         (load),
    .load_val     (load_val),
    .state        (state),
    .cur_dir      (cur_dir),
    .blank_active (blank_active),
    .trip_taken   (trip_taken),
    .rect_on      (rect_on)
  );

  // leg 0 = A, leg 1 = B; the source leg carries the high side in on-time
  for (genvar g = 0; g < NLEG; g++) begin : g_leg
    logic is_src;
    assign is_src    = (cur_dir == g[0]);
    assign hi_req[g] = st_on && is_src;
    assign lo_req[g] = ((st_on || st_off) && !is_src) || (st_off && is_src && rect_on);

    chop_leg u_leg (
      .en     (run),
      .hi_req (hi_req[g]),
      .lo_req (lo_req[g]),
      .hi     (gate_hi[g]),
      .lo     (gate_lo[g]),
      .clash  (leg_clash[g])
    );
  end

  assign hi_a = gate_hi[0];
  assign lo_a = gate_lo[0];
  assign hi_b = gate_hi[1];
  assign lo_b = gate_lo[1];

endmodule

// File: rtl/chop_chk.sv
module chop_chk #(
  parameter int unsigned OFF_CYC  = 1500,
  parameter int unsigned DEAD_CYC = 25
) (
  input logic       clk,
  input logic       rst_n,
  input logic       dir,
  input logic [1:0] level,
  input logic       trip,
  input logic       sleep_n,
  input logic       fault,
  input logic       hi_a,
  input logic       lo_a,
  input logic       hi_b,
  input logic       lo_b,
  input logic [1:0] ref_sel,
  input logic       st_on,
  input logic       st_off,
  input logic       blank_active,
  input logic       rect_on,
  input logic       cur_dir,
  input logic [1:0] leg_clash
);

  logic [31:0] off_len;
  logic        drive_ok;
  logic        any_gate;

  assign drive_ok = sleep_n && !fault && (level != 2'b11);
  assign any_gate = hi_a || lo_a || hi_b || lo_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      off_len <= '0;
    else if (st_off) off_len <= off_len + 1'b1;
    else             off_len <= '0;
  end

  p_gates_off_reset_r1: assert property (@(posedge clk) !rst_n |-> !any_gate);

  p_blank_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_on && blank_active && drive_ok && dir == cur_dir) |=> st_on);

  p_off_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_off) |-> $past(trip));

  p_high_in_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_a || hi_b) |-> st_on);

  p_off_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st_off |-> off_len < OFF_CYC);

  p_rect_late_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_off && off_len < DEAD_CYC) |-> !rect_on);

  p_ref_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ref_sel == level);

  p_zero_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (level == 2'b11) |-> !any_gate);

  p_fault_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !any_gate);

  p_sleep_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n |-> !any_gate);

  p_leg_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_a && lo_a) && !(hi_b && lo_b));

  p_no_clash_r11: assert property (@(posedge clk) disable iff (!rst_n)
    leg_clash == 2'b00);

  p_gap_a_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_a |-> !$past(lo_a)) and (lo_a |-> !$past(hi_a)));

  p_gap_b_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_b |-> !$past(lo_b)) and (lo_b |-> !$past(hi_b)));

endmodule

bind chopper_ctrl chop_chk #(
  .OFF_CYC  (OFF_CYC),
  .DEAD_CYC (DEAD_CYC)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dir          (dir),
  .level        (level),
  .trip         (trip),
  .sleep_n      (sleep_n),
  .fault        (fault),
  .hi_a         (hi_a),
  .lo_a         (lo_a),
  .hi_b         (hi_b),
  .lo_b         (lo_b),
  .ref_sel      (ref_sel),
  .st_on        (st_on),
  .st_off       (st_off),
  .blank_active (blank_active),
  .rect_on      (rect_on),
  .cur_dir      (cur_dir),
  .leg_clash    (leg_clash)
);

// File: tb/tb_chopper_ctrl.sv
`timescale 1ns/1ps
module tb_chopper_ctrl;

  localparam int CLK_PERIOD = 20;
  localparam int KHZ   = 1000;
  localparam int BLANK = 5;
  localparam int DEAD  = 3;
  localparam int OFF   = KHZ * 30 / 1000;   // 30 us at 1 MHz

  logic       clk = 1'b0;
  logic       rst_n;
  logic       dir;
  logic [1:0] level;
  logic       trip;
  logic       sleep_n;
  logic       fault;
  logic       hi_a, lo_a, hi_b, lo_b;
  logic [1:0] ref_sel;

  int  cyc    = 0;
  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  typedef struct {
    int         at;
    logic [3:0] g;     // {hi_a, lo_a, hi_b, lo_b}
    logic [1:0] r;
    string      tag;
  } exp_t;

  exp_t sbq[$];
  exp_t mon_it;

  chopper_ctrl #(
    .CLK_KHZ   (KHZ),
    .SHORT_OFF (1'b0),
    .BLANK_CYC (BLANK),
    .DEAD_CYC  (DEAD)
  ) dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .dir     (dir),
    .level   (level),
    .trip    (trip),
    .sleep_n (sleep_n),
    .fault   (fault),
    .hi_a    (hi_a),
    .lo_a    (lo_a),
    .hi_b    (hi_b),
    .lo_b    (lo_b),
    .ref_sel (ref_sel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic expect_at(input int d, input logic [3:0] g,
                           input logic [1:0] r, input string tag);
    exp_t it;
    int   idx;
    it.at  = cyc + d;
    it.g   = g;
    it.r   = r;
    it.tag = tag;
    idx = sbq.size();
    for (int i = 0; i < sbq.size(); i++) begin
      if (sbq[i].at > it.at) begin
        idx = i;
        break;
      end
    end
    sbq.insert(idx, it);
  endtask

  task automatic expect_span(input int d0, input int d1, input logic [3:0] g,
                             input logic [1:0] r, input string tag);
    for (int d = d0; d <= d1; d++) expect_at(d, g, r, tag);
  endtask

  // monitor: compare queued expectations at the falling edge
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].at <= cyc) begin
      mon_it = sbq.pop_front();
      checks++;
      if (mon_it.at != cyc || {hi_a, lo_a, hi_b, lo_b} !== mon_it.g || ref_sel !== mon_it.r) begin
        fails++;
        $display("FAIL %s cyc %0d: got gates=%b ref=%b expected gates=%b ref=%b",
                 mon_it.tag, cyc, {hi_a, lo_a, hi_b, lo_b}, ref_sel, mon_it.g, mon_it.r);
      end
    end
    if (rst_n === 1'b1) begin
      checks++;
      if ((hi_a && lo_a) || (hi_b && lo_b)) begin
        fails++;
        $display("FAIL R11 cyc %0d: got gates=%b expected no leg with both on",
                 cyc, {hi_a, lo_a, hi_b, lo_b});
      end
    end
  end

  initial begin
    rst_n = 1'b0; fault = 1'b1; dir = 1'b0; level = 2'b00;
    trip = 1'b0; sleep_n = 1'b1;

    // R1: reset holds everything off
    step(1);
    expect_at(0, 4'b0000, 2'b00, "R1");
    step(2);
    expect_at(0, 4'b0000, 2'b00, "R1");
    rst_n = 1'b1;
    // R8: fault still present after reset keeps gates off
    expect_span(0, 2, 4'b0000, 2'b00, "R8");
    step(4);

    // R2: start-up dead time then diagonal A-high / B-low
    fault = 1'b0;
    expect_span(0, DEAD, 4'b0000, 2'b00, "R2");
    expect_at(DEAD + 1, 4'b1001, 2'b00, "R2");
    step(DEAD + 1);

    // R3: trip held through the blanking window is ignored
    trip = 1'b1;
    step(BLANK);
    trip = 1'b0;
    expect_span(1, 2, 4'b1001, 2'b00, "R3");
    step(3);

    // R4/R6/R5: trip, off-time with rectification, dead, new on-time
    trip = 1'b1;
    expect_at(0, 4'b1001, 2'b00, "R4");
    expect_span(1, DEAD, 4'b0001, 2'b00, "R4");
    expect_span(DEAD + 1, OFF, 4'b0101, 2'b00, "R6");
    expect_span(OFF + 1, OFF + DEAD, 4'b0000, 2'b00, "R5");
    expect_at(OFF + DEAD + 1, 4'b1001, 2'b00, "R5");
    step(1);
    trip = 1'b0;
    step(OFF + DEAD);

    // R10: direction change during on-time
    step(BLANK + 2);
    dir = 1'b1;
    expect_at(0, 4'b1001, 2'b00, "R10");
    expect_span(1, DEAD, 4'b0000, 2'b00, "R10");
    expect_at(DEAD + 1, 4'b0110, 2'b00, "R10");
    step(DEAD + 1);

    // R4/R6 on the other diagonal
    step(BLANK);
    trip = 1'b1;
    expect_span(1, DEAD, 4'b0100, 2'b00, "R4");
    expect_span(DEAD + 1, DEAD + 2, 4'b0101, 2'b00, "R6");
    step(1);
    trip = 1'b0;
    step(DEAD + 1);

    // R10: direction change during off-time
    dir = 1'b0;
    expect_at(0, 4'b0101, 2'b00, "R10");
    expect_span(1, DEAD, 4'b0000, 2'b00, "R10");
    expect_at(DEAD + 1, 4'b1001, 2'b00, "R10");
    step(DEAD + 1);

    // R7: level passes through, 11 forces off, release restarts
    step(1);
    level = 2'b01;
    expect_at(0, 4'b1001, 2'b01, "R7");
    step(1);
    level = 2'b10;
    expect_at(0, 4'b1001, 2'b10, "R7");
    step(1);
    level = 2'b11;
    expect_at(0, 4'b0000, 2'b11, "R7");
    expect_at(2, 4'b0000, 2'b11, "R7");
    step(3);
    level = 2'b00;
    expect_span(0, DEAD, 4'b0000, 2'b00, "R7");
    expect_at(DEAD + 1, 4'b1001, 2'b00, "R7");
    step(DEAD + 1);

    // R9: sleep forces off, wake restarts through dead time
    step(2);
    sleep_n = 1'b0;
    expect_at(0, 4'b0000, 2'b00, "R9");
    expect_at(3, 4'b0000, 2'b00, "R9");
    step(4);
    sleep_n = 1'b1;
    expect_span(0, DEAD, 4'b0000, 2'b00, "R9");
    expect_at(DEAD + 1, 4'b1001, 2'b00, "R9");
    step(DEAD + 1);

    // R8: fault in the middle of an off-time
    step(BLANK);
    trip = 1'b1;
    expect_at(1, 4'b0001, 2'b00, "R4");
    step(1);
    trip = 1'b0;
    step(DEAD + 1);
    fault = 1'b1;
    expect_at(0, 4'b0000, 2'b00, "R8");
    expect_at(2, 4'b0000, 2'b00, "R8");
    step(3);
    fault = 1'b0;
    expect_span(0, DEAD, 4'b0000, 2'b00, "R8");
    expect_at(DEAD + 1, 4'b1001, 2'b00, "R8");
    step(DEAD + 2);

    step(2);
    checks++;
    if (sbq.size() != 0) begin
      fails++;
      $display("FAIL R1 end: got %0d pending expectations expected 0", sbq.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog: got hung run expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule